// File: doc/BRIEF.md
# Clocked Serial Shift Port Controller

This block is an 8-bit synchronous serial port for a small controller. A host loads a byte into the shift register, selects an operating mode and a clock source, and issues a start command. The bits then move least significant bit first over a serial clock pin, a data-out pin and a data-in pin. The clock pin is driven by the block when the internal source is selected, and it is an input otherwise. When the transfer finishes, a sticky interrupt request flag is raised.

A three-phase sequencer controls the port. In the idle phase it waits for a start command, in the armed phase it waits for the first clock, and in the shift phase it counts bits. A bit counter decides when a byte is complete. Extra clocks caused by noise wrap the counter and begin a new transfer. Software can detect this case: it clears the flag, rewrites the mode, and sees the flag set again because the rewrite interrupted a transfer.

The block has no prescaler of its own. A one-cycle `tick` enable stands in for one, and it paces the internal clock.

Top module: `sshift_ctrl`

## Requirements
- R1: After reset, `phase` is 00 (idle), `irq` is 0, `sck_o` is 1, `sdo` is 1, `sck_oe` is 0 and `data_rdata` is 0.
- R2: A mode write, or any change of `port_en`, forces the idle phase. It also clears the bit counter and stops the internal clock with `sck_o` back at 1. While `port_en` is 0, `start` is ignored.
- R3: In the idle phase, transfer clock edges leave the shift register and the counter unchanged.
- R4: `start` moves the idle phase to the armed phase (`phase` 01). The first falling transfer-clock edge moves it to the shift phase (`phase` 10) and shifts one bit.
- R5: The falling edge that completes the eighth bit returns the sequencer to the armed phase and sets `irq` on the same clock edge.
- R6: A `start` during the shift phase clears the counter, returns to the armed phase and sets `irq`. A following transfer again needs eight falling edges.
- R7: With the internal clock selected (`mode_intclk`=1), `start` produces exactly eight low pulses on `sck_o`. Each `tick` toggles the pin. After the eighth rising edge the pin stays at 1 whatever `tick` does.
- R8: Mode code 00 (`mode_op`) is continuous clock. `sck_oe` is 1, every `tick` after `start` toggles `sck_o` without end, the sequencer stays armed, and `irq` and the data register are unaffected.
- R9: `mode_op` 01 is transmit only, 10 is receive only and 11 is both. Bit k of the register appears on `sdo` at falling edge k+1. `sdi` is sampled at the following rising edge, and the bit received k-th ends in bit k. In transmit only, the register is back at its loaded value after eight bits. In receive only, `sdo` holds its value.
- R10: A ninth clock re-enters the shift phase. A mode write during the shift phase sets `irq` again, which flags the invalid transfer.
- R11: `irq` stays set until `irq_clr`. When a set and a clear coincide, the set wins.
- R12: An external `sck_i` edge is synchronised by two flops. Its effect shows on the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable level |
| mode_wr | input | 1 | Mode register write strobe |
| mode_op | input | 2 | Operating mode code (00 continuous, 01 tx, 10 rx, 11 tx/rx) |
| mode_intclk | input | 1 | 1 selects the internal transfer clock |
| start | input | 1 | Start command strobe |
| data_wr | input | 1 | Parallel load strobe for the shift register |
| data_wdata | input | 8 | Parallel load data |
| data_rdata | output | 8 | Shift register contents |
| irq | output | 1 | Sticky interrupt request flag |
| irq_clr | input | 1 | Flag clear strobe |
| tick | input | 1 | Prescaler enable pacing the internal clock |
| phase | output | 2 | Sequencer phase (00 idle, 01 armed, 10 shift) |
| sck_i | input | 1 | Serial clock pin input |
| sck_o | output | 1 | Serial clock pin output level |
| sck_oe | output | 1 | Serial clock pin output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Host strobes and internal-clock ticks act on the rising edge that samples them. Their results are read at the following falling edge. An external pin edge takes three rising edges: two synchroniser flops and then the phase or register update. The bench checks the phase at the second falling edge, where it is still unchanged, and at the third, where it has moved. After an `sck_i` change it waits four cycles before reading `sdo`. It holds `sdi` stable across the synchronised rising edge. The internal transfer is driven one `tick` per two cycles, and every falling edge of `sck_o` is observed at the next falling system-clock edge. So the bench records the transmitted bit and the phase on the cycle each bit leaves.

// File: rtl/sshift_pkg.sv
// Package: shared encodings for the serial shift port controller.
// Assumes the phase codes are visible at the top port and are relied on by
// software and by the bench.
package sshift_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_ARMED = 2'b01,
        PH_SHIFT = 2'b10
    } phase_t;

    typedef enum logic [1:0] {
        OP_FREE = 2'b00,
        OP_TX   = 2'b01,
        OP_RX   = 2'b10,
        OP_TRX  = 2'b11
    } op_t;

endpackage

// File: rtl/sshift_clkgen.sv
// Module: transfer clock front end.
// Synchronises the external clock pin and turns its edges into one-cycle
// events. Also generates the internal clock from the prescaler tick: a burst
// of DATA_W low pulses, or a free-running square wave in continuous mode.
// Assumes tick is a single-cycle enable and that sck_pin idles high.
module sshift_clkgen #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sck_pin,
    input  logic use_int,
    input  logic cont,
    input  logic launch,
    input  logic halt,
    output logic sck_lvl,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int PW = $clog2(DATA_W + 1);

    logic [SYNC_STAGES:0] sync_q;
    logic                 pin_now;
    logic                 pin_prev;
    logic                 run_q;
    logic                 lvl_q;
    logic [PW-1:0]        falls_q;
    logic                 gen_go;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], sck_pin};
    end

    assign pin_now  = sync_q[SYNC_STAGES-1];
    assign pin_prev = sync_q[SYNC_STAGES];

    // Internal clock generator: toggles on tick, stops after DATA_W pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            lvl_q   <= 1'b1;
            falls_q <= '0;
        end else if (halt) begin
            run_q   <= 1'b0;
            lvl_q   <= 1'b1;
            falls_q <= '0;
        end else if (launch) begin
            run_q   <= 1'b1;
            lvl_q   <= 1'b1;
            falls_q <= '0;
        end else if (tick && run_q) begin
            lvl_q <= ~lvl_q;
            if (lvl_q && !cont)
                falls_q <= falls_q + 1'b1;
            if (!lvl_q && !cont && falls_q == PW'(DATA_W))
                run_q <= 1'b0;
        end
    end

    // Edge events, taken from the generator or from the synchronised pin.
    always_comb begin
        gen_go = tick & run_q & ~halt & ~launch;
        if (use_int) begin
            fall_ev = gen_go & lvl_q;
            rise_ev = gen_go & ~lvl_q;
        end else begin
            fall_ev = pin_prev & ~pin_now;
            rise_ev = ~pin_prev & pin_now;
        end
    end

    assign sck_lvl = lvl_q;

endmodule

// File: rtl/sshift_seq.sv
// Module: phase sequencer and bit counter.
// Tracks idle / armed / shift and counts qualified falling edges. It raises
// the sticky interrupt flag on a completed byte, or when a transfer is cut
// short by a start or a forced idle.
// Assumes force_idle and start_ok are never high together.
module sshift_seq
    import sshift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   force_idle,
    input  logic   start_ok,
    input  logic   fall_ev,
    input  logic   cont,
    input  logic   irq_clr,
    output phase_t phase,
    output logic   irq,
    output logic   shift_ev,
    output logic   irq_set
);
    localparam int            CW   = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    // Qualify clock edges and decide when the flag must be raised.
    always_comb begin
        shift_ev = fall_ev & ~cont & (phase != PH_IDLE) & ~force_idle & ~start_ok;
        wrap     = shift_ev & (phase == PH_SHIFT) & (cnt_q == LAST);
        irq_set  = wrap | ((force_idle | start_ok) & (phase == PH_SHIFT));
    end

    // Phase and bit counter update; forced idle outranks start, start outranks edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else if (force_idle) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else if (start_ok) begin
            phase <= PH_ARMED;
            cnt_q <= '0;
        end else if (shift_ev) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            phase <= wrap ? PH_ARMED : PH_SHIFT;
        end
    end

    // Sticky interrupt flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

endmodule

// File: rtl/sshift_datapath.sv
// Module: shift register and serial data pins.
// On each qualified falling edge it drives bit 0 to sdo and rotates the
// register right. On the next rising edge the received bit replaces the top bit.
// Assumes sdi is stable around the rising edge that samples it.
module sshift_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_ev,
    input  logic              rise_ev,
    input  logic              flush,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              sdi,
    output logic [DATA_W-1:0] shreg,
    output logic              sdo
);
    logic pend_q;

    // Shift register: host load, rotate on falling edge, capture on rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                       shreg <= '0;
        else if (load)                    shreg <= load_data;
        else if (shift_ev)                shreg <= {shreg[0], shreg[DATA_W-1:1]};
        else if (rise_ev && pend_q && rx_en) shreg[DATA_W-1] <= sdi;
    end

    // Pending-sample flag linking each falling edge to the next rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (flush)    pend_q <= 1'b0;
        else if (shift_ev) pend_q <= 1'b1;
        else if (rise_ev)  pend_q <= 1'b0;
    end

    // Serial output: updated only when transmitting, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sdo <= 1'b1;
        else if (shift_ev && tx_en) sdo <= shreg[0];
    end

endmodule

// File: rtl/sshift_ctrl.sv
// Module: top of the serial shift port controller.
// Holds the mode register, detects changes of the port enable and wires the
// clock front end, the sequencer and the datapath together.
// Assumes host strobes are single-cycle and synchronous to clk.
module sshift_ctrl
    import sshift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              mode_wr,
    input  logic [1:0]        mode_op,
    input  logic              mode_intclk,
    input  logic              start,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              irq,
    input  logic              irq_clr,
    input  logic              tick,
    output logic [1:0]        phase,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo,
    input  logic              sdi
);
    logic [1:0] op_q;
    logic       intclk_q;
    logic       port_q;
    logic       port_chg;
    logic       force_idle;
    logic       start_ok;
    logic       cont;
    logic       use_int;
    logic       launch;
    logic       fall_ev;
    logic       rise_ev;
    logic       shift_ev;
    logic       irq_set;
    phase_t     phase_w;

    // Mode register and port enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_FREE;
            intclk_q <= 1'b0;
            port_q   <= 1'b0;
        end else begin
            port_q <= port_en;
            if (mode_wr) begin
                op_q     <= mode_op;
                intclk_q <= mode_intclk;
            end
        end
    end

    // Control decode shared by the sub-blocks.
    always_comb begin
        port_chg   = port_en ^ port_q;
        force_idle = mode_wr | port_chg | ~port_en;
        start_ok   = start & port_en & ~mode_wr & ~port_chg;
        cont       = port_en & (op_q == OP_FREE);
        use_int    = intclk_q | (op_q == OP_FREE);
        launch     = start_ok & use_int;
    end

    sshift_clkgen #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sck_pin (sck_i),
        .use_int (use_int),
        .cont    (cont),
        .launch  (launch),
        .halt    (force_idle),
        .sck_lvl (sck_o),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    sshift_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_idle (force_idle),
        .start_ok   (start_ok),
        .fall_ev    (fall_ev),
        .cont       (cont),
        .irq_clr    (irq_clr),
        .phase      (phase_w),
        .irq        (irq),
        .shift_ev   (shift_ev),
        .irq_set    (irq_set)
    );

    sshift_datapath #(
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_wr),
        .load_data (data_wdata),
        .shift_ev  (shift_ev),
        .rise_ev   (rise_ev),
        .flush     (force_idle | start_ok),
        .tx_en     (op_q[0]),
        .rx_en     (op_q[1]),
        .sdi       (sdi),
        .shreg     (data_rdata),
        .sdo       (sdo)
    );

    assign phase  = phase_w;
    assign sck_oe = port_en & use_int;

endmodule

// File: rtl/sshift_ctrl_chk.sv
// Module: property checker for the serial shift port controller.
// Bound into every instance of the top. It only observes and drives nothing.
module sshift_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase,
    input logic              irq,
    input logic              irq_clr,
    input logic              irq_set,
    input logic              data_wr,
    input logic [DATA_W-1:0] data_rdata,
    input logic              cont,
    input logic              sck_o
);
    // R3: the idle phase leaves the register alone unless the host loads it.
    a_r3_idle_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && !data_wr) |=> $stable(data_rdata));

    // R4: shifting is reachable only through the armed phase.
    a_r4_no_skip_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00) |=> (phase != 2'b10));

    // R5: leaving the shift phase for the armed phase always raises the flag.
    a_r5_exit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10) |=> (phase != 2'b01 || irq));

    // R8: continuous clock mode never enters the shift phase.
    a_r8_free_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        cont |-> (phase != 2'b10));

    // R2: in the idle phase the generated clock rests high.
    a_r2_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00) |-> sck_o);

    // R11: the flag is held until a clear arrives.
    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R11: a clear without a simultaneous set drops the flag.
    a_r11_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set) |=> !irq);

endmodule

bind sshift_ctrl sshift_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .irq        (irq),
    .irq_clr    (irq_clr),
    .irq_set    (irq_set),
    .data_wr    (data_wr),
    .data_rdata (data_rdata),
    .cont       (cont),
    .sck_o      (sck_o)
);

// File: tb/sshift_ctrl_test.sv
`timescale 1ns/1ps
// Bench: sweeps modes and data patterns of the serial shift port with the
// internal clock, then exercises the external clock, noise, abort, port
// enable and continuous clock cases. All results are sampled on falling edges.
module sshift_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_op = 2'b00;
    logic       mode_intclk = 1'b0;
    logic       start = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic [7:0] data_rdata;
    logic       irq;
    logic       irq_clr = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] phase;
    logic       sck_i = 1'b1;
    logic       sck_o;
    logic       sck_oe;
    logic       sdo;
    logic       sdi = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sshift_ctrl uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode_wr(mode_wr),
        .mode_op(mode_op), .mode_intclk(mode_intclk), .start(start),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .irq(irq), .irq_clr(irq_clr), .tick(tick), .phase(phase),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] op, input logic ic);
        mode_op = op; mode_intclk = ic; mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic load(input logic [7:0] d);
        data_wdata = d; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic one_tick(output int tog);
        logic prev;
        prev = sck_o; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        tog = (sck_o != prev) ? 1 : 0;
        @(negedge clk);
    endtask

    // Internal-clock transfer: 18 ticks, one per two cycles, recording bits.
    task automatic run_int(input logic [7:0] rxp, input bit clr_last,
                           output logic [7:0] txb, output int nfall,
                           output int ntog, output logic [1:0] ph_first);
        logic prev;
        prev = sck_o; nfall = 0; ntog = 0; txb = '0; ph_first = 2'b11;
        for (int t = 0; t < 18; t++) begin
            tick = 1'b1; irq_clr = clr_last && (t == 14);
            @(negedge clk); tick = 1'b0; irq_clr = 1'b0;
            if (sck_o != prev) ntog++;
            if (prev && !sck_o) begin
                if (nfall < 8) begin
                    txb[nfall] = sdo;
                    sdi = rxp[nfall];
                end
                if (nfall == 0) ph_first = phase;
                nfall++;
            end
            prev = sck_o;
            @(negedge clk);
        end
    endtask

    // One external clock pulse carrying receive bit b; returns sdo after the fall.
    task automatic ext_bit(input logic b, output logic so);
        sck_i = 1'b0; sdi = b;
        cyc(4); so = sdo;
        sck_i = 1'b1;
        cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] txb, rx, d;
        logic [1:0] phf;
        logic       so, sdo0;
        int         nf, nt, tg, acc;

        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state
        check("R1 phase", phase, 0);
        check("R1 irq", irq, 0);
        check("R1 sck_o", sck_o, 1);
        check("R1 sdo", sdo, 1);
        check("R1 sck_oe", sck_oe, 0);
        check("R1 data", data_rdata, 0);

        port_en = 1'b1; cyc(1);

        // R9 R7 R5 R4 sweep of modes and data with the internal clock
        for (int op = 1; op < 4; op++) begin
            for (int k = 0; k < 4; k++) begin
                d  = (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : (k == 2) ? 8'h01 : 8'hFE;
                rx = d ^ 8'h5B;
                set_mode(op[1:0], 1'b1);
                load(d);
                pulse_clr();
                pulse_start();
                check("R4 armed after start", phase, 1);
                sdo0 = sdo;
                run_int(rx, 1'b0, txb, nf, nt, phf);
                check("R4 shift after first fall", phf, 2);
                check("R7 falling edges", nf, 8);
                check("R7 toggles", nt, 16);
                check("R7 idle high", sck_o, 1);
                check("R5 irq", irq, 1);
                check("R5 back to armed", phase, 1);
                if (op == 1) begin
                    check("R9 tx bits", txb, d);
                    check("R9 tx rotate back", data_rdata, d);
                end else if (op == 2) begin
                    check("R9 rx sdo held", txb, sdo0 ? 8'hFF : 8'h00);
                    check("R9 rx data", data_rdata, rx);
                end else begin
                    check("R9 trx bits", txb, d);
                    check("R9 trx data", data_rdata, rx);
                end
            end
        end

        // R11 set wins over a coincident clear, then sticky and clear
        set_mode(2'b11, 1'b1); load(8'h77); pulse_start();
        run_int(8'h00, 1'b1, txb, nf, nt, phf);
        check("R11 set beats clear", irq, 1);
        cyc(3);
        check("R11 sticky", irq, 1);
        pulse_clr();
        check("R11 cleared", irq, 0);

        // R2 R10 mode write during an internal transfer
        set_mode(2'b11, 1'b1); pulse_start();
        for (int i = 0; i < 3; i++) one_tick(tg);
        check("R2 mid transfer low", sck_o, 0);
        check("R4 mid transfer shift", phase, 2);
        set_mode(2'b11, 1'b1);
        check("R2 clock released high", sck_o, 1);
        check("R2 forced idle", phase, 0);
        check("R10 irq on mode write", irq, 1);
        acc = 0;
        for (int i = 0; i < 4; i++) begin one_tick(tg); acc += tg; end
        check("R2 clock halted", acc, 0);

        // R3 external clock ignored while idle
        pulse_clr();
        set_mode(2'b11, 1'b0);
        load(8'h5A);
        check("R3 sck_oe external", sck_oe, 0);
        for (int i = 0; i < 10; i++) ext_bit(1'b1, so);
        check("R3 data kept", data_rdata, 8'h5A);
        check("R3 still idle", phase, 0);
        check("R3 no irq", irq, 0);

        // R12 R4 R9 R5 external transfer
        rx = 8'hC6; txb = '0;
        pulse_start();
        check("R4 armed ext", phase, 1);
        sck_i = 1'b0; sdi = rx[0];
        cyc(2);
        check("R12 not yet", phase, 1);
        cyc(1);
        check("R12 third edge", phase, 2);
        cyc(1); txb[0] = sdo; sck_i = 1'b1; cyc(4);
        for (int b = 1; b < 8; b++) begin ext_bit(rx[b], so); txb[b] = so; end
        check("R9 ext tx bits", txb, 8'h5A);
        check("R9 ext rx data", data_rdata, rx);
        check("R5 ext irq", irq, 1);
        check("R5 ext armed", phase, 1);

        // R10 noise: nine clocks then a mode write
        pulse_clr(); load(8'h96);
        for (int b = 0; b < 8; b++) ext_bit(1'b0, so);
        check("R10 irq at eighth", irq, 1);
        check("R10 armed at eighth", phase, 1);
        ext_bit(1'b0, so);
        check("R10 ninth re-enters", phase, 2);
        pulse_clr();
        check("R10 cleared", irq, 0);
        set_mode(2'b11, 1'b0);
        check("R10 idle after write", phase, 0);
        check("R10 flag again", irq, 1);

        // R6 start during a transfer
        pulse_clr(); pulse_start();
        for (int b = 0; b < 3; b++) ext_bit(1'b0, so);
        check("R6 shifting", phase, 2);
        pulse_start();
        check("R6 aborted to armed", phase, 1);
        check("R6 irq", irq, 1);
        pulse_clr();
        for (int b = 0; b < 7; b++) ext_bit(1'b0, so);
        check("R6 counter restarted", phase, 2);
        check("R6 no early irq", irq, 0);
        ext_bit(1'b0, so);
        check("R6 full byte", phase, 1);
        check("R6 irq after byte", irq, 1);

        // R2 port enable change and disabled start
        port_en = 1'b0; cyc(1);
        check("R2 disable idles", phase, 0);
        pulse_start();
        check("R2 start ignored", phase, 0);
        port_en = 1'b1; cyc(1);
        check("R2 enable idles", phase, 0);

        // R8 continuous clock mode
        pulse_clr();
        load(8'hC3);
        set_mode(2'b00, 1'b0);
        check("R8 drives clock", sck_oe, 1);
        pulse_start();
        acc = 0;
        for (int i = 0; i < 20; i++) begin one_tick(tg); acc += tg; end
        check("R8 toggles", acc, 20);
        check("R8 stays armed", phase, 1);
        check("R8 no irq", irq, 0);
        check("R8 data kept", data_rdata, 8'hC3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule